// File: doc/BRIEF.md
# Per-Bank Refresh Scheduler with Occupancy-Driven Bank Choice

This block is the refresh-control slice of a DRAM controller serving one rank of several banks. A free-running interval timer adds one owed refresh to every bank each interval. The scheduler then decides which bank to refresh and when. It does not follow a fixed rotation. It favours banks whose demand queues are empty. It lets owed refreshes pile up while demand traffic is present, up to a forcing limit. While the controller drains its write queue, it issues owed refreshes eagerly.

Each cycle the block offers at most one refresh, as a request plus a bank number. The command arbiter accepts the offer by raising a grant in the same cycle. An accepted refresh retires one owed refresh of that bank and marks the bank busy for the refresh busy time. The other banks stay available to demand traffic. A mode input selects the plain rotating order instead, for comparison.

Top module: `bank_refresh_sched`

## Requirements
- R1: Starting from reset, every bank gains one owed refresh on the INTERVAL-th rising edge and again on every INTERVAL-th edge after that. An owed count saturates at its maximum.
- R2: `ref_req` is high only while the offered bank owes at least one refresh. An offer is accepted when `ref_req` and `slot_grant` are both high at a rising edge. Acceptance removes exactly one owed refresh from that bank. Once a bank's debt reaches zero, it is no longer offered.
- R3: After acceptance, `bank_busy` for that bank is high for exactly BUSY_CYC cycles, beginning in the cycle after acceptance. A busy bank is never offered. The busy flags of the other banks are unaffected.
- R4: In occupancy mode (`sel_occupancy`=1) with `drain_mode`=0, a bank is eligible only if its pending count is zero. The exception is a bank whose owed count has reached OWE_LIMIT, which is eligible regardless of its pending count.
- R5: In occupancy mode with `drain_mode`=1, any non-busy bank that owes a refresh is eligible, whatever its pending count.
- R6: In occupancy mode, the offered bank is picked in this order: first a bank at the forcing limit, then the fewest pending requests, then the highest owed count, then the lowest bank index. A non-busy bank at the forcing limit always causes `ref_req` to be high.
- R7: In rotating mode (`sel_occupancy`=0), only the bank at a rotation pointer can be offered. It is offered when it owes a refresh and is not busy, whatever its pending count. The pointer is 0 after reset and advances by one, wrapping to 0, on each accepted refresh.
- R8: During and straight after reset, `ref_req` is low, `bank_busy` is all zero, and no bank owes a refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_occupancy | input | 1 | 1: occupancy-driven choice, 0: rotating order |
| drain_mode | input | 1 | Controller is draining its write queue |
| pend_cnt | input | NUM_BANKS*CNT_W | Pending demand count per bank, bank b at bits [b*CNT_W +: CNT_W] |
| slot_grant | input | 1 | Command slot given to the offered refresh this cycle |
| ref_req | output | 1 | A refresh is offered this cycle |
| ref_bank | output | BANK_W | Bank index of the offered refresh |
| bank_busy | output | NUM_BANKS | Per-bank refresh-in-progress flag |

## Verification
On every cycle, the assertions check the following. An offered bank is never busy and always owes a refresh. Acceptance makes the bank busy on the next cycle. A non-busy bank at the forcing limit always produces an offer. In occupancy mode outside drain, a non-forced offer goes only to a bank with an empty queue. Only the bench scenarios can show the rest: the exact interval and busy-window lengths, the full priority order among competing banks, the pointer walk and wrap of the rotating mode, and the retiring of debt down to zero.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    SEL_ROTATE    = 1'b0,
    SEL_OCCUPANCY = 1'b1
  } sel_mode_e;

  // Owed-count update for one cycle: +1 on tick (saturating), -1 on issue.
  function automatic int unsigned owed_next(input int unsigned cur,
                                            input logic tick,
                                            input logic issue,
                                            input int unsigned max_val);
    int unsigned r;
    r = cur;
    if (tick && !issue && cur != max_val) r = cur + 1;
    else if (!tick && issue && cur != 0) r = cur - 1;
    return r;
  endfunction

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int unsigned INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (tick)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R1: ticks are separated by the interval, never back to back
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/rs_bank_slot.sv
module rs_bank_slot #(
  parameter int unsigned OWE_W     = 4,
  parameter int unsigned OWE_LIMIT = 8,
  parameter int unsigned BUSY_CYC  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             issue,
  output logic [OWE_W-1:0] owed,
  output logic             forced,
  output logic             busy
);
  localparam int unsigned OWE_MAX = (1 << OWE_W) - 1;
  localparam int unsigned BW      = $clog2(BUSY_CYC + 1);

  logic [OWE_W-1:0] owed_q;
  logic [BW-1:0]    busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= OWE_W'(rs_pkg::owed_next(int'(owed_q), tick, issue, OWE_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              busy_q <= '0;
    else if (issue)          busy_q <= BW'(BUSY_CYC);
    else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
  end

  assign owed   = owed_q;
  assign busy   = (busy_q != '0);
  assign forced = (owed_q >= OWE_W'(OWE_LIMIT));

  // R2/R3: an accepted refresh hits a bank that owes one and is idle
  p_issue_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (owed_q != '0) && !busy);

  // R3: acceptance makes the bank busy in the following cycle
  p_busy_after_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> busy);

endmodule

// File: rtl/rs_picker.sv
module rs_picker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned OWE_W     = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_occupancy,
  input  logic                       drain_mode,
  input  logic [NUM_BANKS*CNT_W-1:0] pend_cnt,
  input  logic [NUM_BANKS*OWE_W-1:0] owed_flat,
  input  logic [NUM_BANKS-1:0]       forced,
  input  logic [NUM_BANKS-1:0]       busy,
  input  logic [BANK_W-1:0]          rr_ptr,
  output logic                       pick_valid,
  output logic [BANK_W-1:0]          pick_bank
);
  localparam int unsigned KEY_W = 1 + CNT_W + OWE_W;

  // Larger key wins: forced first, then fewer pending, then more owed.
  function automatic logic [KEY_W-1:0] rank_key(input logic f,
                                                input logic [CNT_W-1:0] p,
                                                input logic [OWE_W-1:0] o);
    return {f, ~p, o};
  endfunction

  logic [NUM_BANKS-1:0] elig_occ;
  logic [NUM_BANKS-1:0] elig_rot;
  logic [KEY_W-1:0]     key [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] p_b;
    logic [OWE_W-1:0] o_b;
    assign p_b         = pend_cnt[b*CNT_W +: CNT_W];
    assign o_b         = owed_flat[b*OWE_W +: OWE_W];
    assign elig_rot[b] = (o_b != '0) && !busy[b];
    assign elig_occ[b] = elig_rot[b] && (drain_mode || (p_b == '0) || forced[b]);
    assign key[b]      = rank_key(forced[b], p_b, o_b);
  end

  always_comb begin
    logic [KEY_W-1:0] best;
    best       = '0;
    pick_valid = 1'b0;
    pick_bank  = '0;
    if (sel_occupancy) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (elig_occ[b] && (!pick_valid || key[b] > best)) begin
          pick_valid = 1'b1;
          pick_bank  = BANK_W'(b);
          best       = key[b];
        end
      end
    end else begin
      pick_valid = elig_rot[rr_ptr];
      pick_bank  = rr_ptr;
    end
  end

  // R4: outside drain, a non-forced occupancy pick has an empty queue
  p_idle_queue_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && sel_occupancy && !drain_mode && !forced[pick_bank])
      |-> (pend_cnt[pick_bank*CNT_W +: CNT_W] == '0));

endmodule

// File: rtl/bank_refresh_sched.sv
module bank_refresh_sched #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned INTERVAL  = 64,
  parameter int unsigned BUSY_CYC  = 12,
  parameter int unsigned OWE_LIMIT = 8,
  parameter int unsigned OWE_W     = 4,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_occupancy,
  input  logic                       drain_mode,
  input  logic [NUM_BANKS*CNT_W-1:0] pend_cnt,
  input  logic                       slot_grant,
  output logic                       ref_req,
  output logic [BANK_W-1:0]          ref_bank,
  output logic [NUM_BANKS-1:0]       bank_busy
);
  import rs_pkg::*;

  function automatic logic [BANK_W-1:0] step_ptr(input logic [BANK_W-1:0] p);
    return (p == BANK_W'(NUM_BANKS - 1)) ? '0 : p + 1'b1;
  endfunction

  logic                       tick;
  logic                       accept;
  logic [NUM_BANKS-1:0]       issue_vec;
  logic [NUM_BANKS-1:0]       forced;
  logic [NUM_BANKS*OWE_W-1:0] owed_flat;
  logic [BANK_W-1:0]          rr_ptr_q;
  sel_mode_e                  mode;

  assign mode   = sel_mode_e'(sel_occupancy);
  assign accept = ref_req && slot_grant;

  rs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    assign issue_vec[b] = accept && (ref_bank == BANK_W'(b));
    rs_bank_slot #(
      .OWE_W     (OWE_W),
      .OWE_LIMIT (OWE_LIMIT),
      .BUSY_CYC  (BUSY_CYC)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .issue  (issue_vec[b]),
      .owed   (owed_flat[b*OWE_W +: OWE_W]),
      .forced (forced[b]),
      .busy   (bank_busy[b])
    );
  end

  rs_picker #(
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W),
    .OWE_W     (OWE_W),
    .BANK_W    (BANK_W)
  ) u_pick (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_occupancy (sel_occupancy),
    .drain_mode    (drain_mode),
    .pend_cnt      (pend_cnt),
    .owed_flat     (owed_flat),
    .forced        (forced),
    .busy          (bank_busy),
    .rr_ptr        (rr_ptr_q),
    .pick_valid    (ref_req),
    .pick_bank     (ref_bank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                          rr_ptr_q <= '0;
    else if (accept && mode == SEL_ROTATE) rr_ptr_q <= step_ptr(rr_ptr_q);
  end

  // R3: an offered bank is never one already refreshing
  p_offer_not_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !bank_busy[ref_bank]);

  // R6: an idle bank at the forcing limit always yields an offer
  p_forced_offer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_occupancy && |(forced & ~bank_busy)) |-> ref_req);

  // R2: the offered bank owes at least one refresh
  p_offer_owes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (owed_flat[ref_bank*OWE_W +: OWE_W] != '0));

  // R7: in rotating mode the offer is always the pointer bank
  p_rotate_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !sel_occupancy) |-> (ref_bank == rr_ptr_q));

endmodule

// File: tb/bank_refresh_sched_tb.sv
module bank_refresh_sched_tb;
  localparam int unsigned NB = 4;
  localparam int unsigned CW = 4;
  localparam int unsigned IV = 32;
  localparam int unsigned BC = 5;
  localparam int unsigned LIM = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sel_occupancy = 1'b1;
  logic            drain_mode = 1'b0;
  logic [NB*CW-1:0] pend_cnt = '0;
  logic            slot_grant = 1'b0;
  logic            ref_req;
  logic [1:0]      ref_bank;
  logic [NB-1:0]   bank_busy;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bank_refresh_sched #(
    .NUM_BANKS (NB), .CNT_W (CW), .INTERVAL (IV),
    .BUSY_CYC (BC), .OWE_LIMIT (LIM), .OWE_W (4)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .sel_occupancy (sel_occupancy),
    .drain_mode (drain_mode), .pend_cnt (pend_cnt), .slot_grant (slot_grant),
    .ref_req (ref_req), .ref_bank (ref_bank), .bank_busy (bank_busy)
  );

  typedef struct packed {
    logic [15:0] pend;
    logic        drain;
    logic        req;
    logic [1:0]  bank;
  } vec_t;

  // all banks owe 2 refreshes while this table is walked
  localparam vec_t VEC [8] = '{
    '{16'h0203, 1'b0, 1'b1, 2'd1},  // R4 empty queues 1,3 -> lowest index
    '{16'h4321, 1'b0, 1'b0, 2'd0},  // R4 no empty queue -> postponed
    '{16'h4321, 1'b1, 1'b1, 2'd0},  // R5 drain -> fewest pending
    '{16'h3125, 1'b1, 1'b1, 2'd2},  // R6 fewest pending is bank 2
    '{16'h4444, 1'b1, 1'b1, 2'd0},  // R6 full tie -> lowest index
    '{16'h0002, 1'b0, 1'b1, 2'd1},  // R4 bank 0 busy with demand
    '{16'h1110, 1'b0, 1'b1, 2'd0},  // R4 only bank 0 idle
    '{16'h9099, 1'b1, 1'b1, 2'd2}   // R5 drain, bank 2 empty
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic occ);
    rst_n = 1'b0; slot_grant = 1'b0; drain_mode = 1'b0;
    sel_occupancy = occ; pend_cnt = '0;
    step(2);
    #1;
    chk("R8 req in reset", int'(ref_req), 0);
    chk("R8 busy in reset", int'(bank_busy), 0);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // Scenario A: reset, first tick timing, busy window
    do_reset(1'b1);
    step(IV - 1); #1;
    chk("R1 no debt before first tick", int'(ref_req), 0);
    chk("R8 busy clear after reset", int'(bank_busy), 0);
    step(1); #1;
    chk("R1 debt after first tick", int'(ref_req), 1);
    chk("R6 lowest index on tie", int'(ref_bank), 0);
    slot_grant = 1'b1;
    step(1); slot_grant = 1'b0; #1;
    chk("R3 busy only bank0", int'(bank_busy), 1);
    chk("R2 next offer bank1", int'(ref_bank), 1);
    step(BC - 1); #1;
    chk("R3 still busy at last cycle", int'(bank_busy[0]), 1);
    step(1); #1;
    chk("R3 busy ends after window", int'(bank_busy[0]), 0);

    // Scenario B: table walk, owed = 2 on each bank
    do_reset(1'b1);
    step(2 * IV + 1);
    for (int i = 0; i < 8; i++) begin
      pend_cnt = VEC[i].pend; drain_mode = VEC[i].drain;
      #1;
      chk($sformatf("R4/R5/R6 vec%0d req", i), int'(ref_req), int'(VEC[i].req));
      if (VEC[i].req)
        chk($sformatf("R6 vec%0d bank", i), int'(ref_bank), int'(VEC[i].bank));
      step(1);
    end

    // Scenario C: busy exclusion and debt retirement
    do_reset(1'b1);
    pend_cnt = 16'h5550;
    step(2 * IV + 2); #1;
    chk("R4 only idle bank0 offered", int'(ref_bank), 0);
    slot_grant = 1'b1; step(1); slot_grant = 1'b0; #1;
    chk("R3 busy bank not offered", int'(ref_req), 0);
    step(BC); #1;
    chk("R2 remaining debt offered", int'(ref_req), 1);
    chk("R2 remaining debt bank", int'(ref_bank), 0);
    slot_grant = 1'b1; step(1); slot_grant = 1'b0;
    step(BC); #1;
    chk("R2 debt retired to zero", int'(ref_req), 0);

    // Scenario D: forcing limit overrides empty queue
    do_reset(1'b1);
    pend_cnt = 16'h3330;
    slot_grant = 1'b1;
    step(LIM * IV - 1); #1;
    chk("R4 no forced offer before limit", int'(ref_req), 0);
    step(1); #1;
    chk("R6 forced wins over empty queue", int'(ref_bank), 1);
    step(1); #1;
    chk("R6 forced next bank2", int'(ref_bank), 2);
    step(1); #1;
    chk("R6 forced next bank3", int'(ref_bank), 3);
    step(1); #1;
    chk("R4 then idle bank0", int'(ref_bank), 0);
    slot_grant = 1'b0;

    // Scenario E: rotating mode
    do_reset(1'b0);
    step(2 * IV + 1); #1;
    chk("R7 pointer starts at 0", int'(ref_bank), 0);
    slot_grant = 1'b1;
    step(1); #1;
    chk("R7 pointer moves to 1 despite bank0 debt", int'(ref_bank), 1);
    step(1); #1;
    chk("R7 pointer 2", int'(ref_bank), 2);
    step(1); #1;
    chk("R7 pointer 3", int'(ref_bank), 3);
    step(1); slot_grant = 1'b0; #1;
    chk("R7 wrap waits on busy bank0", int'(ref_req), 0);
    pend_cnt = 16'h0007;
    step(2); #1;
    chk("R7 wrapped offer ignores pending", int'(ref_req), 1);
    chk("R7 wrapped to bank0", int'(ref_bank), 0);

    summary();
  end

endmodule